// File: doc/BRIEF.md
# Timer Capture/Compare Channel Action Unit

This block is one channel of a general-purpose timer. Every timer clock it looks at a shared counter value, its own compare/capture register and a capture strobe that an upstream circuit has already edge-detected. From these it updates up to four event outputs. A 4-bit action code chooses what it does. On a compare match it can pulse, set, clear or toggle the events. It can also combine set-or-clear at counter zero with toggle on match, which gives edge-aligned or centre-aligned PWM. In capture mode it copies the counter value into its register and sets the events.

Each action comes in a repeating form and a one-shot form. The one-shot form drops its own event enables after the first trigger, and the channel then stays idle. The counter, the prescaler, input synchronisation and the bus interface sit outside the block. The configuration word and the channel register are loaded through plain write strobes and can be read back on output ports. All outputs are registered. An input sampled at a clock edge shows its effect right after that edge.

Top module: `cc_channel_unit`

## Requirements
- R1: After reset, the configuration word reads 0, the channel register reads 0 and all event outputs are 0.
- R2: In the configuration word, bits 3:0 hold the action code and bits 7:4 hold the enables for events 0 to 3. A written word reads back unchanged until the block changes the enables itself. Code 0 (disabled) and code 8 (measurement, handled outside this unit) never change any event.
- R3: Code 15 drives every enabled event high for exactly two clock cycles after a match, where a match is channel register equal to counter. The events then return low.
- R4: A match sets the enabled events under code 13, clears them under code 12 and inverts them under code 14. Events whose enable bit is 0 keep their value in every mode.
- R5: Under code 11, counter zero sets the enabled events and a match then toggles them. With the register at 0, counter zero clears them instead. Over one period of a counter running 0..T, the events are high for min(C, T+1) cycles.
- R6: Under code 10, counter zero clears the enabled events and a match toggles them. With the register at 0, counter zero sets them. The high time per period is T+1-min(C, T+1).
- R7: Under code 9, a capture strobe copies the counter into the channel register and sets the enabled events. A register write in the same cycle takes priority over the copy.
- R8: Codes 7 to 1 behave like codes 15 to 9 respectively, except that all enable bits drop to 0 after the first match (codes 7 to 2) or the first capture (code 1). Later matches or captures then change neither the events nor the register.
- R9: While the action code is 0 or 8, the event outputs hold whatever value they last had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load strobe for the configuration word |
| cfgWdata | input | 8 | Configuration word: action code in 3:0, event enables in 7:4 |
| cfgRdata | output | 8 | Current configuration word |
| ccWe | input | 1 | Load strobe for the channel register |
| ccWdata | input | 16 | Value to load into the channel register |
| ccValue | output | 16 | Current channel register |
| cnt | input | 16 | Shared timer counter value |
| captStrobe | input | 1 | Edge-detected capture request |
| evOut | output | 4 | Event outputs 0 to 3 |

## Verification
The bench sweeps the register value from 0 up to past the counter top in both PWM modes and counts high cycles per period. A design that got the register-zero rule wrong would give a one-cycle glitch instead of a solid 0% or 100% duty. A design that toggled before the zero action would give an inverted duty. The pulse mode is checked sample by sample, which catches pulses of one or three cycles. The one-shot modes are run across a second trigger, which exposes a unit that keeps firing or keeps capturing after it should have disarmed. Idle codes and cleared enable bits are swept while matches occur, which catches events that leak through.

// File: rtl/cc_unit_pkg.sv
package cc_unit_pkg;
  localparam int ACT_W = 4;

  // Low three bits of the action code select the function; bit 3 selects repeat.
  localparam logic [2:0] FN_PULSE   = 3'd7;
  localparam logic [2:0] FN_TOGGLE  = 3'd6;
  localparam logic [2:0] FN_SET     = 3'd5;
  localparam logic [2:0] FN_CLEAR   = 3'd4;
  localparam logic [2:0] FN_Z_SET   = 3'd3;
  localparam logic [2:0] FN_Z_CLEAR = 3'd2;
  localparam logic [2:0] FN_CAPTURE = 3'd1;

  typedef struct packed {
    logic doSet;
    logic doClr;
    logic doTgl;
    logic doPulse;
    logic doCapt;
    logic doDisarm;
  } ccStrobe_t;
endpackage

// File: rtl/cc_unit_ctrl.sv
module cc_unit_ctrl
  import cc_unit_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int EV_N  = 4
) (
  input  logic [ACT_W-1:0] action,
  input  logic [EV_N-1:0]  evEn,
  input  logic [CNT_W-1:0] ccReg,
  input  logic [CNT_W-1:0] cnt,
  input  logic             captStrobe,
  output ccStrobe_t        strb
);
  logic [2:0] func;
  logic       repeatMode;
  logic       armed;
  logic       match;
  logic       atZero;
  logic       coinc;
  logic       trigger;
  ccStrobe_t  raw;

  assign func       = action[2:0];
  assign repeatMode = action[ACT_W-1];
  assign match      = (ccReg == cnt);
  assign atZero     = (cnt == '0);
  assign coinc      = atZero && (ccReg == '0);
  // Idle codes 0 and 8; a one-shot with no enables left is also idle.
  assign armed = (func != 3'd0) && (repeatMode || (evEn != '0));

  always_comb begin
    raw     = '0;
    trigger = 1'b0;
    case (func)
      FN_PULSE: begin
        raw.doSet   = match;
        raw.doPulse = match;
        trigger     = match;
      end
      FN_TOGGLE: begin
        raw.doTgl = match;
        trigger   = match;
      end
      FN_SET: begin
        raw.doSet = match;
        trigger   = match;
      end
      FN_CLEAR: begin
        raw.doClr = match;
        trigger   = match;
      end
      FN_Z_SET: begin
        if (coinc) raw.doClr = 1'b1;
        else begin
          raw.doSet = atZero;
          raw.doTgl = match;
        end
        trigger = match;
      end
      FN_Z_CLEAR: begin
        if (coinc) raw.doSet = 1'b1;
        else begin
          raw.doClr = atZero;
          raw.doTgl = match;
        end
        trigger = match;
      end
      FN_CAPTURE: begin
        raw.doSet  = captStrobe;
        raw.doCapt = captStrobe;
        trigger    = captStrobe;
      end
      default: ;
    endcase
    raw.doDisarm = trigger && !repeatMode;
    strb = armed ? raw : '0;
  end
endmodule

// File: rtl/cc_unit_dpath.sv
module cc_unit_dpath
  import cc_unit_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int EV_N  = 4,
  localparam int CFG_W = ACT_W + EV_N
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             ccWe,
  input  logic [CNT_W-1:0] ccWdata,
  input  logic [CNT_W-1:0] cnt,
  input  ccStrobe_t        strb,
  output logic [ACT_W-1:0] action,
  output logic [EV_N-1:0]  evEn,
  output logic [CNT_W-1:0] ccReg,
  output logic [EV_N-1:0]  evOut
);
  logic [1:0]      pulseStage;
  logic [EV_N-1:0] pulseMask;
  logic [EV_N-1:0] evNext;

  // Apply order: end of a running pulse, then zero action, then match toggle.
  always_comb begin
    evNext = evOut;
    if (pulseStage == 2'd1) evNext = evNext & ~pulseMask;
    if (strb.doSet)         evNext = evNext | evEn;
    if (strb.doClr)         evNext = evNext & ~evEn;
    if (strb.doTgl)         evNext = evNext ^ evEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      action     <= '0;
      evEn       <= '0;
      ccReg      <= '0;
      evOut      <= '0;
      pulseStage <= '0;
      pulseMask  <= '0;
    end else begin
      if (cfgWe) {evEn, action} <= cfgWdata;
      else if (strb.doDisarm) evEn <= '0;

      if (ccWe) ccReg <= ccWdata;
      else if (strb.doCapt) ccReg <= cnt;

      evOut <= evNext;

      if (strb.doPulse) begin
        pulseStage <= 2'd2;
        pulseMask  <= evEn;
      end else if (pulseStage != 2'd0) begin
        pulseStage <= pulseStage - 2'd1;
      end
    end
  end
endmodule

// File: rtl/cc_channel_unit.sv
module cc_channel_unit
  import cc_unit_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int EV_N  = 4,
  localparam int CFG_W = ACT_W + EV_N
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  input  logic             ccWe,
  input  logic [CNT_W-1:0] ccWdata,
  output logic [CNT_W-1:0] ccValue,
  input  logic [CNT_W-1:0] cnt,
  input  logic             captStrobe,
  output logic [EV_N-1:0]  evOut
);
  ccStrobe_t        strb;
  logic [ACT_W-1:0] action;
  logic [EV_N-1:0]  evEn;

  cc_unit_ctrl #(.CNT_W(CNT_W), .EV_N(EV_N)) ctrl_i (
    .action(action), .evEn(evEn), .ccReg(ccValue), .cnt(cnt),
    .captStrobe(captStrobe), .strb(strb)
  );

  cc_unit_dpath #(.CNT_W(CNT_W), .EV_N(EV_N)) dpath_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .ccWe(ccWe), .ccWdata(ccWdata), .cnt(cnt), .strb(strb),
    .action(action), .evEn(evEn), .ccReg(ccValue), .evOut(evOut)
  );

  assign cfgRdata = {evEn, action};
endmodule

// File: rtl/cc_channel_unit_chk.sv
module cc_channel_unit_chk #(
  parameter int CNT_W = 16,
  parameter int EV_N  = 4,
  localparam int CFG_W = 4 + EV_N
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [CFG_W-1:0] cfgRdata,
  input logic             ccWe,
  input logic [CNT_W-1:0] ccValue,
  input logic [CNT_W-1:0] cnt,
  input logic             captStrobe,
  input logic [EV_N-1:0]  evOut
);
  logic [3:0]      act;
  logic [EV_N-1:0] en;
  logic            idleAct;
  logic            hit;

  assign act     = cfgRdata[3:0];
  assign en      = cfgRdata[CFG_W-1:4];
  assign idleAct = (act == 4'd0) || (act == 4'd8);
  assign hit     = (ccValue == cnt);

  // R3
  pulse_two_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (act == 4'd15 && hit && en[0] && !cfgWe) |=> evOut[0] ##1 evOut[0]);

  // R8
  oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (act >= 4'd2 && act <= 4'd7 && en != '0 && hit && !cfgWe) |=> (en == '0));

  // R7
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((act == 4'd9 || (act == 4'd1 && en != '0)) && captStrobe && !ccWe)
      |=> (ccValue == $past(cnt)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idleAct && $past(idleAct) && $past(idleAct, 2) && $past(idleAct, 3))
      |-> $stable(evOut));

  // R4
  set_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (act == 4'd13 && hit && !cfgWe) |=> ((evOut & $past(en)) == $past(en)));

  // R5
  zero_coinc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (act == 4'd11 && cnt == '0 && ccValue == '0 && !cfgWe)
      |=> ((evOut & $past(en)) == '0));
endmodule

bind cc_channel_unit cc_channel_unit_chk #(.CNT_W(CNT_W), .EV_N(EV_N)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRdata(cfgRdata), .ccWe(ccWe),
  .ccValue(ccValue), .cnt(cnt), .captStrobe(captStrobe), .evOut(evOut)
);

// File: tb/cc_channel_unit_tb_top.sv
`timescale 1ns/1ps
module cc_channel_unit_tb_top;
  localparam int TOP = 7;
  localparam logic [15:0] SAFE = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic        ccWe = 1'b0;
  logic [15:0] ccWdata = '0;
  logic [15:0] ccValue;
  logic [15:0] cnt = SAFE;
  logic        captStrobe = 1'b0;
  logic [3:0]  evOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cc_channel_unit dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .ccWe(ccWe), .ccWdata(ccWdata), .ccValue(ccValue), .cnt(cnt),
    .captStrobe(captStrobe), .evOut(evOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] c);
    cnt = c;
    @(posedge clk);
    #1;
  endtask

  task automatic writeCc(input logic [15:0] v);
    ccWdata = v; ccWe = 1'b1;
    step(SAFE);
    ccWe = 1'b0;
  endtask

  task automatic writeCfg(input logic [3:0] act, input logic [3:0] en);
    cfgWdata = {en, act}; cfgWe = 1'b1;
    step(SAFE);
    cfgWe = 1'b0;
    check(cfgRdata == {en, act}, "R2 readback", cfgRdata, {en, act});
  endtask

  task automatic capture(input logic [15:0] c);
    captStrobe = 1'b1;
    step(c);
    captStrobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    step(SAFE);
    // R1 reset state
    check(evOut == 4'h0, "R1 events", evOut, 0);
    check(cfgRdata == 8'h00, "R1 config", cfgRdata, 0);
    check(ccValue == 16'h0, "R1 register", ccValue, 0);

    // R9 disabled with enables set: matches at zero must not act
    writeCfg(4'd0, 4'hF);
    for (int c = 0; c <= TOP; c++) begin
      step(16'(c));
      check(evOut == 4'h0, "R9 disabled hold", evOut, 0);
    end

    // R3 repeating pulse, two periods
    writeCc(16'd3);
    writeCfg(4'd15, 4'b0001);
    for (int p = 0; p < 2; p++)
      for (int c = 0; c <= TOP; c++) begin
        step(16'(c));
        check(evOut == ((c == 3 || c == 4) ? 4'b0001 : 4'b0000), "R3 pulse", evOut,
              (c == 3 || c == 4) ? 1 : 0);
      end

    // R8 one-shot pulse on event 1
    writeCfg(4'd7, 4'b0010);
    for (int p = 0; p < 2; p++)
      for (int c = 0; c <= TOP; c++) begin
        step(16'(c));
        check(evOut == ((p == 0 && (c == 3 || c == 4)) ? 4'b0010 : 4'b0000),
              "R8 one-shot pulse", evOut, (p == 0 && (c == 3 || c == 4)) ? 2 : 0);
      end
    check(cfgRdata == 8'h07, "R8 enables dropped", cfgRdata, 8'h07);

    // R4 set / clear / toggle with enable masking
    writeCc(16'd5);
    writeCfg(4'd13, 4'b0011);
    step(16'd5);
    check(evOut == 4'b0011, "R4 set", evOut, 4'b0011);
    writeCfg(4'd12, 4'b0001);
    step(16'd5);
    check(evOut == 4'b0010, "R4 clear masked", evOut, 4'b0010);
    writeCfg(4'd14, 4'b0011);
    step(16'd5);
    check(evOut == 4'b0001, "R4 toggle", evOut, 4'b0001);
    step(16'd5);
    check(evOut == 4'b0010, "R4 toggle back", evOut, 4'b0010);
    step(16'd4);
    check(evOut == 4'b0010, "R4 no match", evOut, 4'b0010);

    // R9 / R2 idle codes hold a nonzero state
    writeCfg(4'd0, 4'hF);
    for (int c = 0; c <= TOP; c++) begin
      step(16'(c));
      check(evOut == 4'b0010, "R9 code0 hold", evOut, 4'b0010);
    end
    writeCfg(4'd8, 4'hF);
    for (int c = 0; c <= TOP; c++) begin
      step(16'(c));
      check(evOut == 4'b0010, "R2 code8 inert", evOut, 4'b0010);
    end

    // R8 one-shot toggle
    writeCfg(4'd6, 4'b0100);
    step(16'd5);
    check(evOut == 4'b0110, "R8 one-shot toggle", evOut, 4'b0110);
    check(cfgRdata == 8'h06, "R8 toggle disarm", cfgRdata, 8'h06);
    step(16'd5);
    check(evOut == 4'b0110, "R8 no second toggle", evOut, 4'b0110);

    // R7 capture
    writeCfg(4'd9, 4'b1000);
    capture(16'h0055);
    check(ccValue == 16'h0055, "R7 copy", ccValue, 16'h55);
    check(evOut == 4'b1110, "R7 set", evOut, 4'b1110);
    ccWdata = 16'h0021; ccWe = 1'b1;
    capture(16'h0077);
    ccWe = 1'b0;
    check(ccValue == 16'h0021, "R7 write priority", ccValue, 16'h21);
    writeCfg(4'd1, 4'b0001);
    capture(16'h0012);
    check(ccValue == 16'h0012, "R8 one-shot capture", ccValue, 16'h12);
    check(evOut == 4'b1111, "R8 capture set", evOut, 4'b1111);
    check(cfgRdata == 8'h01, "R8 capture disarm", cfgRdata, 8'h01);
    capture(16'h0034);
    check(ccValue == 16'h0012, "R8 no second capture", ccValue, 16'h12);

    // R5 / R6 PWM duty sweep on event 0; events 3:1 must stay put
    for (int m = 0; m < 2; m++)
      for (int cc = 0; cc <= TOP + 2; cc++) begin
        logic [3:0] upper;
        int highs;
        int expHighs;
        int lim;
        writeCc(16'(cc));
        writeCfg(m == 0 ? 4'd11 : 4'd10, 4'b0001);
        upper = evOut & 4'b1110;
        for (int c = 0; c <= TOP; c++) step(16'(c));
        highs = 0;
        for (int c = 0; c <= TOP; c++) begin
          step(16'(c));
          if (evOut[0]) highs++;
        end
        lim = (cc < TOP + 1) ? cc : TOP + 1;
        expHighs = (m == 0) ? lim : TOP + 1 - lim;
        if (m == 0) check(highs == expHighs, "R5 duty", highs, expHighs);
        else        check(highs == expHighs, "R6 duty", highs, expHighs);
        check((evOut & 4'b1110) == upper, "R4 masked bits", evOut, upper);
      end

    // R8 one-shot set-on-zero/toggle: one period of output, then idle
    writeCc(16'd4);
    writeCfg(4'd3, 4'b0001);
    for (int p = 0; p < 2; p++)
      for (int c = 0; c <= TOP; c++) begin
        step(16'(c));
        check(evOut[0] == (p == 0 && c < 4), "R8 one-shot pwm", evOut[0], (p == 0 && c < 4));
      end
    check(cfgRdata == 8'h03, "R8 pwm disarm", cfgRdata, 8'h03);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule